// File: doc/BRIEF.md
# Speculative Store Buffer

This block keeps the address and data of store operations between the time they execute and the time they may safely change memory. A store enters with the sequence tag of its instruction and stays speculative until the commit logic confirms it. It leaves in one of three ways: an abort for that tag discards it, a flush throws away every store that is still speculative, or, once committed, it is written out through a drain port toward the data cache. Memory is never written by a store that has not committed.

Loads look up the buffer every cycle. A load that matches the address of one or more buffered stores older than itself takes its data from the youngest of those stores, in preference to anything the cache holds. Sequence tags wrap around, so every age decision uses the sign of the tag difference taken modulo the tag width.

Top module: `spec_store_buf`

## Requirements
- R1: After reset the buffer holds no store: `alloc_full_o` is 0, `drn_valid_o` is 0 and no load hits.
- R2: A request with `alloc_valid_i` high while `alloc_full_o` is low (and no flush) stores tag, address and data in a free entry; the entry is speculative and visible to loads from the next cycle.
- R3: When every entry is occupied, `alloc_full_o` is 1 and an allocation request in that cycle leaves the buffer unchanged.
- R4: A commit for the tag of a speculative entry makes that entry non-speculative; the drain port can offer it from the next cycle.
- R5: An abort for the tag of a speculative entry removes it; from the next cycle loads no longer match it and it is never drained.
- R6: A load whose address equals a buffered older store reports `ld_hit_o`=1 with that store's data on `ld_data_o` in the same cycle, whether the store is speculative or committed; the buffer result takes priority over the cache.
- R7: With several matching stores, a load forwards from the youngest store strictly older than its own tag; stores with an equal or younger tag are ignored.
- R8: Store A is older than B when bit TAG_W-1 of (tagA - tagB) mod 2^TAG_W is 1, so ages stay correct across tag wrap.
- R9: The drain port offers only valid, committed entries; a speculative store is never presented.
- R10: Committed stores drain oldest tag first, one per cycle; an entry is freed in the cycle after `drn_valid_o` and `drn_ready_i` are both high.
- R11: A flush removes every speculative entry in one cycle and keeps committed entries; an allocation request in the flush cycle is not performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid_i | input | 1 | Executed store presented for allocation |
| alloc_tag_i | input | TAG_W | Sequence tag of the store |
| alloc_addr_i | input | ADDR_W | Store address |
| alloc_data_i | input | DATA_W | Store data |
| alloc_full_o | output | 1 | No free entry; requester holds the store |
| commit_valid_i | input | 1 | Commit of a store |
| commit_tag_i | input | TAG_W | Tag of the committing store |
| abort_valid_i | input | 1 | Abort of a store |
| abort_tag_i | input | TAG_W | Tag of the aborted store |
| flush_i | input | 1 | Drop all speculative entries |
| ld_valid_i | input | 1 | Load lookup request |
| ld_tag_i | input | TAG_W | Sequence tag of the load |
| ld_addr_i | input | ADDR_W | Load address |
| ld_hit_o | output | 1 | An older matching store was found |
| ld_data_o | output | DATA_W | Forwarded store data |
| drn_valid_o | output | 1 | A committed store is offered to the cache |
| drn_addr_o | output | ADDR_W | Address of the offered store |
| drn_data_o | output | DATA_W | Data of the offered store |
| drn_ready_i | input | 1 | Cache accepts the offered store |

## Verification
The load result is combinational, so each lookup is checked a short settle time after its inputs change and before the next clock edge. Allocation, commit, abort, flush and drain acceptance all take effect at the first clock edge after they are driven, so their consequences are read through the load port, `alloc_full_o` or the drain port one cycle later, with inputs changed just after the edge. Drain order is checked entry by entry, reading the offered store before each accepting edge.

// File: rtl/ssb_pkg.sv
// Shared helpers for the store buffer.
// Assumes tag widths below 32 bits.
package ssb_pkg;

    // True when tag a is older than tag b under wrapping sequence numbers.
    function automatic logic tag_older(input logic [31:0] a,
                                       input logic [31:0] b,
                                       input int unsigned w);
        logic [31:0] msk;
        logic [31:0] dif;
        msk = (32'd1 << w) - 32'd1;
        dif = (a - b) & msk;
        return dif[w-1];
    endfunction

endpackage

// File: rtl/ssb_alloc.sv
// Free-entry picker: returns the lowest-numbered empty entry and
// raises full when every entry is occupied.
module ssb_alloc #(
    parameter int NUM_ENT = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_ENT-1:0] vld,
    output logic               full,
    output logic [IDX_W-1:0]   free_idx
);

    // Priority scan over the occupancy mask.
    always_comb begin
        logic found;
        found    = 1'b0;
        free_idx = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (!vld[i] && !found) begin
                free_idx = IDX_W'(i);
                found    = 1'b1;
            end
        end
        full = &vld;
    end

endmodule

// File: rtl/ssb_drain_sel.sv
// Drain selector: among valid committed entries, picks the one with the
// oldest sequence tag. Assumes at most one entry per tag.
module ssb_drain_sel #(
    parameter int NUM_ENT = 4,
    parameter int TAG_W   = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_ENT-1:0]            vld,
    input  logic [NUM_ENT-1:0]            spec,
    input  logic [NUM_ENT-1:0][TAG_W-1:0] tags,
    output logic                          sel_valid,
    output logic [IDX_W-1:0]              sel_idx
);
    import ssb_pkg::*;

    // Age-ordered reduction over committed entries.
    always_comb begin
        logic [TAG_W-1:0] best;
        best      = '0;
        sel_valid = 1'b0;
        sel_idx   = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (vld[i] && !spec[i] &&
                (!sel_valid || tag_older(32'(tags[i]), 32'(best), TAG_W))) begin
                sel_valid = 1'b1;
                sel_idx   = IDX_W'(i);
                best      = tags[i];
            end
        end
    end

endmodule

// File: rtl/ssb_fwd.sv
// Load forwarding: finds the youngest buffered store with a matching
// address whose tag is strictly older than the load tag.
module ssb_fwd #(
    parameter int NUM_ENT = 4,
    parameter int TAG_W   = 4,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16
) (
    input  logic                           ld_valid,
    input  logic [TAG_W-1:0]               ld_tag,
    input  logic [ADDR_W-1:0]              ld_addr,
    input  logic [NUM_ENT-1:0]             vld,
    input  logic [NUM_ENT-1:0][TAG_W-1:0]  tags,
    input  logic [NUM_ENT-1:0][ADDR_W-1:0] addrs,
    input  logic [NUM_ENT-1:0][DATA_W-1:0] datas,
    output logic                           hit,
    output logic [DATA_W-1:0]              data
);
    import ssb_pkg::*;

    // Youngest-older match reduction.
    always_comb begin
        logic [TAG_W-1:0] best;
        logic             match;
        best = '0;
        hit  = 1'b0;
        data = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            match = ld_valid && vld[i] && (addrs[i] == ld_addr) &&
                    tag_older(32'(tags[i]), 32'(ld_tag), TAG_W);
            if (match && (!hit || tag_older(32'(best), 32'(tags[i]), TAG_W))) begin
                hit  = 1'b1;
                best = tags[i];
                data = datas[i];
            end
        end
    end

endmodule

// File: rtl/spec_store_buf.sv
// Speculative store buffer top. Holds executed stores until commit and
// committed stores until the cache takes them. Assumes tags of live
// stores are unique and span less than half the tag space.
module spec_store_buf #(
    parameter int NUM_ENT = 4,
    parameter int TAG_W   = 4,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid_i,
    input  logic [TAG_W-1:0]  alloc_tag_i,
    input  logic [ADDR_W-1:0] alloc_addr_i,
    input  logic [DATA_W-1:0] alloc_data_i,
    output logic              alloc_full_o,
    input  logic              commit_valid_i,
    input  logic [TAG_W-1:0]  commit_tag_i,
    input  logic              abort_valid_i,
    input  logic [TAG_W-1:0]  abort_tag_i,
    input  logic              flush_i,
    input  logic              ld_valid_i,
    input  logic [TAG_W-1:0]  ld_tag_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    output logic              ld_hit_o,
    output logic [DATA_W-1:0] ld_data_o,
    output logic              drn_valid_o,
    output logic [ADDR_W-1:0] drn_addr_o,
    output logic [DATA_W-1:0] drn_data_o,
    input  logic              drn_ready_i
);
    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

    logic [NUM_ENT-1:0]             vld_q;
    logic [NUM_ENT-1:0]             spec_q;
    logic [NUM_ENT-1:0][TAG_W-1:0]  tag_q;
    logic [NUM_ENT-1:0][ADDR_W-1:0] addr_q;
    logic [NUM_ENT-1:0][DATA_W-1:0] data_q;
    logic [IDX_W-1:0]               free_idx;
    logic [IDX_W-1:0]               drn_idx;
    logic                           alloc_fire;
    logic                           drain_fire;

    ssb_alloc #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) alloc_i (
        .vld      (vld_q),
        .full     (alloc_full_o),
        .free_idx (free_idx)
    );

    ssb_drain_sel #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W), .IDX_W(IDX_W)) drain_i (
        .vld       (vld_q),
        .spec      (spec_q),
        .tags      (tag_q),
        .sel_valid (drn_valid_o),
        .sel_idx   (drn_idx)
    );

    ssb_fwd #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) fwd_i (
        .ld_valid (ld_valid_i),
        .ld_tag   (ld_tag_i),
        .ld_addr  (ld_addr_i),
        .vld      (vld_q),
        .tags     (tag_q),
        .addrs    (addr_q),
        .datas    (data_q),
        .hit      (ld_hit_o),
        .data     (ld_data_o)
    );

    // Handshake qualifiers for allocation and drain.
    always_comb begin
        alloc_fire = alloc_valid_i && !alloc_full_o && !flush_i;
        drain_fire = drn_valid_o && drn_ready_i;
        drn_addr_o = addr_q[drn_idx];
        drn_data_o = data_q[drn_idx];
    end

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        // Valid and speculative state transitions of one entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[e]  <= 1'b0;
                spec_q[e] <= 1'b0;
            end else if (flush_i && vld_q[e] && spec_q[e]) begin
                vld_q[e]  <= 1'b0;
                spec_q[e] <= 1'b0;
            end else begin
                if (abort_valid_i && vld_q[e] && spec_q[e] && tag_q[e] == abort_tag_i)
                    vld_q[e] <= 1'b0;
                else if (commit_valid_i && vld_q[e] && spec_q[e] && tag_q[e] == commit_tag_i)
                    spec_q[e] <= 1'b0;
                if (drain_fire && drn_idx == IDX_W'(e))
                    vld_q[e] <= 1'b0;
                if (alloc_fire && free_idx == IDX_W'(e)) begin
                    vld_q[e]  <= 1'b1;
                    spec_q[e] <= 1'b1;
                end
            end
        end

        // Payload capture at allocation.
        always_ff @(posedge clk) begin
            if (alloc_fire && free_idx == IDX_W'(e)) begin
                tag_q[e]  <= alloc_tag_i;
                addr_q[e] <= alloc_addr_i;
                data_q[e] <= alloc_data_i;
            end
        end
    end

endmodule

// File: rtl/ssb_checker.sv
// Property checker for the store buffer, attached by bind.
module ssb_checker #(
    parameter int NUM_ENT = 4,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               alloc_valid_i,
    input logic               alloc_full_o,
    input logic               abort_valid_i,
    input logic               flush_i,
    input logic               ld_valid_i,
    input logic               ld_hit_o,
    input logic               drn_valid_o,
    input logic               drn_ready_i,
    input logic [IDX_W-1:0]   drn_idx,
    input logic [IDX_W-1:0]   free_idx,
    input logic [NUM_ENT-1:0] vld_q,
    input logic [NUM_ENT-1:0] spec_q
);

    p_reset_empty_r1: assert property (@(posedge clk) !rst_n |=> vld_q == '0);

    p_alloc_spec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid_i && !alloc_full_o && !flush_i
        |=> vld_q[$past(free_idx)] && spec_q[$past(free_idx)]);

    p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_full_o && !(drn_valid_o && drn_ready_i) && !abort_valid_i && !flush_i
        |=> alloc_full_o);

    p_hit_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit_o |-> ld_valid_i && (vld_q != '0));

    p_drain_committed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        drn_valid_o |-> vld_q[drn_idx] && !spec_q[drn_idx]);

    p_drain_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drn_valid_o && drn_ready_i |=> !vld_q[$past(drn_idx)]);

    p_flush_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (vld_q & spec_q) == '0);

endmodule

bind spec_store_buf ssb_checker #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_valid_i (alloc_valid_i),
    .alloc_full_o  (alloc_full_o),
    .abort_valid_i (abort_valid_i),
    .flush_i       (flush_i),
    .ld_valid_i    (ld_valid_i),
    .ld_hit_o      (ld_hit_o),
    .drn_valid_o   (drn_valid_o),
    .drn_ready_i   (drn_ready_i),
    .drn_idx       (drn_idx),
    .free_idx      (free_idx),
    .vld_q         (vld_q),
    .spec_q        (spec_q)
);

// File: tb/spec_store_buf_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table followed by directed cases.
module spec_store_buf_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid_i = 1'b0;
    logic [3:0]  alloc_tag_i = '0;
    logic [15:0] alloc_addr_i = '0;
    logic [15:0] alloc_data_i = '0;
    logic        alloc_full_o;
    logic        commit_valid_i = 1'b0;
    logic [3:0]  commit_tag_i = '0;
    logic        abort_valid_i = 1'b0;
    logic [3:0]  abort_tag_i = '0;
    logic        flush_i = 1'b0;
    logic        ld_valid_i = 1'b0;
    logic [3:0]  ld_tag_i = '0;
    logic [15:0] ld_addr_i = '0;
    logic        ld_hit_o;
    logic [15:0] ld_data_o;
    logic        drn_valid_o;
    logic [15:0] drn_addr_o;
    logic [15:0] drn_data_o;
    logic        drn_ready_i = 1'b0;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    spec_store_buf dut_i (.*);

    // op: 0 alloc, 1 commit, 2 abort, 3 load check
    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  tag;
        logic [15:0] addr;
        logic [15:0] data;
        logic        hit;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 4'd1, 16'h0010, 16'h00A1, 1'b0},  // R2
        '{2'd0, 4'd3, 16'h0010, 16'h00A3, 1'b0},  // R2
        '{2'd0, 4'd5, 16'h0020, 16'h00B5, 1'b0},  // R2
        '{2'd3, 4'd4, 16'h0010, 16'h00A3, 1'b1},  // R7 youngest older
        '{2'd3, 4'd2, 16'h0010, 16'h00A1, 1'b1},  // R7
        '{2'd3, 4'd1, 16'h0010, 16'h0000, 1'b0},  // R7 equal tag ignored
        '{2'd3, 4'd9, 16'h0030, 16'h0000, 1'b0},  // R6 no address match
        '{2'd3, 4'd9, 16'h0020, 16'h00B5, 1'b1},  // R6
        '{2'd2, 4'd3, 16'h0000, 16'h0000, 1'b0},  // R5 abort
        '{2'd3, 4'd4, 16'h0010, 16'h00A1, 1'b1},  // R5
        '{2'd1, 4'd1, 16'h0000, 16'h0000, 1'b0},  // R4 commit
        '{2'd3, 4'd9, 16'h0010, 16'h00A1, 1'b1}   // R6 committed still forwards
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_alloc(input logic [3:0] t, input logic [15:0] a, input logic [15:0] d);
        alloc_valid_i = 1'b1; alloc_tag_i = t; alloc_addr_i = a; alloc_data_i = d;
        step();
        alloc_valid_i = 1'b0;
    endtask

    task automatic do_commit(input logic [3:0] t);
        commit_valid_i = 1'b1; commit_tag_i = t;
        step();
        commit_valid_i = 1'b0;
    endtask

    task automatic do_abort(input logic [3:0] t);
        abort_valid_i = 1'b1; abort_tag_i = t;
        step();
        abort_valid_i = 1'b0;
    endtask

    task automatic do_flush();
        flush_i = 1'b1;
        step();
        flush_i = 1'b0;
    endtask

    task automatic ld_chk(input string rq, input logic [3:0] t, input logic [15:0] a,
                          input logic eh, input logic [15:0] ed);
        ld_valid_i = 1'b1; ld_tag_i = t; ld_addr_i = a;
        #1;
        chk({rq, " hit"}, 32'(ld_hit_o), 32'(eh));
        if (eh) chk({rq, " data"}, 32'(ld_data_o), 32'(ed));
        ld_valid_i = 1'b0;
    endtask

    task automatic drain_chk(input string rq, input logic [15:0] ea, input logic [15:0] ed);
        chk({rq, " drn_valid"}, 32'(drn_valid_o), 32'd1);
        chk({rq, " drn_addr"}, 32'(drn_addr_o), 32'(ea));
        chk({rq, " drn_data"}, 32'(drn_data_o), 32'(ed));
        drn_ready_i = 1'b1;
        step();
        drn_ready_i = 1'b0;
    endtask

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        #1;
        // R1: empty after reset
        chk("R1 full", 32'(alloc_full_o), 32'd0);
        chk("R1 drain", 32'(drn_valid_o), 32'd0);
        ld_chk("R1", 4'd5, 16'h0000, 1'b0, 16'h0);

        for (int i = 0; i < NV; i++) begin
            case (TBL[i].op)
                2'd0: do_alloc(TBL[i].tag, TBL[i].addr, TBL[i].data);
                2'd1: do_commit(TBL[i].tag);
                2'd2: do_abort(TBL[i].tag);
                default: ld_chk($sformatf("table %0d", i), TBL[i].tag, TBL[i].addr,
                                TBL[i].hit, TBL[i].data);
            endcase
        end

        // R9/R10: committed tag1 drains, speculative tag5 stays
        #1;
        drain_chk("R10", 16'h0010, 16'h00A1);
        chk("R9 spec not drained", 32'(drn_valid_o), 32'd0);
        ld_chk("R10 freed", 4'd9, 16'h0010, 1'b0, 16'h0);

        // R11: flush drops speculative, keeps committed
        do_alloc(4'd6, 16'h0040, 16'h00C6);
        do_commit(4'd5);
        do_flush();
        ld_chk("R11 spec gone", 4'd9, 16'h0040, 1'b0, 16'h0);
        ld_chk("R11 committed kept", 4'd9, 16'h0020, 1'b1, 16'h00B5);
        drain_chk("R4", 16'h0020, 16'h00B5);
        chk("R10 empty", 32'(drn_valid_o), 32'd0);

        // R3: full buffer refuses allocation
        for (int k = 0; k < 4; k++)
            do_alloc(4'(8 + k), 16'(16'h0060 + k), 16'(16'h0E00 + k));
        chk("R3 full", 32'(alloc_full_o), 32'd1);
        do_alloc(4'd12, 16'h0077, 16'h0777);
        ld_chk("R3 refused", 4'd13, 16'h0077, 1'b0, 16'h0);
        ld_chk("R3 kept", 4'd13, 16'h0063, 1'b1, 16'h0E03);
        do_flush();
        chk("R11 full cleared", 32'(alloc_full_o), 32'd0);
        ld_chk("R11 all spec gone", 4'd13, 16'h0060, 1'b0, 16'h0);

        // R8: ages across tag wrap, R10 drain order by age not slot
        do_alloc(4'd14, 16'h0050, 16'h0D14);
        do_alloc(4'd15, 16'h0050, 16'h0D15);
        ld_chk("R8 wrap older", 4'd0, 16'h0050, 1'b1, 16'h0D15);
        do_abort(4'd14);
        do_alloc(4'd0, 16'h0050, 16'h0D00);
        ld_chk("R8 wrap youngest", 4'd1, 16'h0050, 1'b1, 16'h0D00);
        ld_chk("R8 younger ignored", 4'd15, 16'h0050, 1'b0, 16'h0);
        do_commit(4'd15);
        do_commit(4'd0);
        drain_chk("R10 first", 16'h0050, 16'h0D15);
        drain_chk("R10 second", 16'h0050, 16'h0D00);
        chk("R10 done", 32'(drn_valid_o), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule